// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive path just after the line decoder. It watches the first six bytes of each incoming frame (the destination address) and a length value that the framer supplies, and it produces a single accept or reject strobe per frame. With that strobe it reports whether the frame is unicast, broadcast or multicast, and whether the multicast address is in the IP multicast range. Frame storage and FCS checking belong to neighbouring blocks.

The basic filter compares unicast frames against one station address and multicast frames against a small set of exact-match slots. A promiscuous flag skips these basic checks. A second filtering layer can be switched on. It checks unicast frames against its own station address and checks multicast frames against a 32768-entry single-bit table. That table sits in internal RAM and is written one 32-bit word at a time. A length gate handles the four extra bytes of a tagged frame when oversized frames are not allowed.

Top module: `rx_addr_filter`

## Requirements
- R1: The frame is classified as unicast when bit 0 of destination byte 0 is 0, as broadcast when all six destination bytes are 0xFF, and as multicast otherwise. Exactly one of `is_ucast_o`, `is_bcast_o`, `is_mcast_o` is high during a decision strobe.
- R2: `is_ipmc_o` is high on a multicast frame whose destination bytes 0, 1 and 2 are 0x01, 0x00 and 0x5E. It is never high on any other frame.
- R3: All 48-bit address inputs carry destination byte k on bits [8k+7:8k]. In basic filtering, a unicast frame is accepted only when its destination equals `sta_addr_i`.
- R4: A broadcast frame is rejected when `bcast_rej_i` is set, unless promiscuous mode is on and the second filtering layer is off.
- R5: In basic filtering, a multicast frame is rejected when `mcast_rej_i` is set. Otherwise it is accepted only if its destination equals one of the `NUM_MC` slots. Slot s occupies bits [48s+47:48s] of `mc_addr_i`.
- R6: When `promisc_i` is set, the checks of R3 and R5 and the broadcast check of R4 are skipped in basic filtering.
- R7: The second filtering layer applies only when both `ext_fn_en_i` and `ext_mc_en_i` are set, and it applies whatever the promiscuous flag says. In that layer, unicast must equal `xsta_addr_i` and broadcast still obeys `bcast_rej_i`. A frame must pass this layer in addition to basic filtering.
- R8: In the second layer, a multicast frame is accepted only if table bit idx is set, where idx = ((byte4 & 0x7F) << 8) | byte5. The bit is stored in word idx[14:5], at bit idx[4:0]. A write with `bmap_we_i` stores `bmap_wdata_i` at word `bmap_waddr_i`.
- R9: When `jumbo_en_i` is clear, a frame with a length of 1519 to 1522 bytes is rejected unless `vlan_en_i` is set. This length gate does not affect any other length.
- R10: Exactly one strobe (`accept_o` or `reject_o`, never both) occurs per frame. It occurs on the clock edge after the edge at which both byte 5 and the length have been registered. Further bytes and lengths are ignored until the next `sof_i`.
- R11: After reset, every output is low until a decision is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Marks the first byte of a frame; valid together with byte_valid_i |
| byte_valid_i | input | 1 | Frame byte present on byte_i |
| byte_i | input | 8 | Frame byte |
| len_valid_i | input | 1 | Frame length present on len_i |
| len_i | input | LEN_W | Frame length in bytes |
| sta_addr_i | input | 48 | Station address for basic unicast match |
| mc_addr_i | input | 48*NUM_MC | Multicast exact-match slots |
| xsta_addr_i | input | 48 | Station address used by the second layer |
| promisc_i | input | 1 | Skip the basic checks |
| bcast_rej_i | input | 1 | Reject broadcast frames |
| mcast_rej_i | input | 1 | Reject multicast frames in basic filtering |
| jumbo_en_i | input | 1 | Oversized frames allowed |
| vlan_en_i | input | 1 | Tagged length window allowed |
| ext_fn_en_i | input | 1 | Second-layer function enable |
| ext_mc_en_i | input | 1 | Second-layer multicast enable |
| bmap_we_i | input | 1 | Table word write strobe |
| bmap_waddr_i | input | BMAP_AW | Table word address |
| bmap_wdata_i | input | WORD_W | Table word data |
| accept_o | output | 1 | Frame accepted strobe |
| reject_o | output | 1 | Frame rejected strobe (receive-reject status) |
| is_ucast_o | output | 1 | Unicast class, valid with the strobe |
| is_bcast_o | output | 1 | Broadcast class, valid with the strobe |
| is_mcast_o | output | 1 | Multicast class, valid with the strobe |
| is_ipmc_o | output | 1 | IP multicast range, valid with the strobe |

## Verification
The length gate and the address checks decide the same frame in the same cycle. The bench drives lengths at the edges of the tagged window while the destination would be accepted or rejected on address alone, and it expects a rejection whenever either check fails. The second case is the arrival of the length together with the byte that completes the address, compared with its arrival afterwards. The bench provokes this by placing the length strobe on a different byte of each frame. It then checks that exactly one strobe appears, one or two cycles after the last byte, and that the strobe carries the value the bench model predicts.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES  = 6;
  localparam int MAC_W       = 8 * ADDR_BYTES;
  localparam int BMAP_IDX_W  = 15;
  localparam int STD_MAX_LEN = 1518;
  localparam int TAG_MAX_LEN = 1522;
  // bytes 2,1,0 packed little-endian
  localparam logic [23:0] IPMC_PFX = 24'h5E0001;

  typedef struct packed {
    logic ucast;
    logic bcast;
    logic mcast;
    logic ipmc;
  } frame_cls_t;
endpackage

// File: rtl/rxf_capture.sv
module rxf_capture
  import rxf_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             len_valid_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [MAC_W-1:0] dst_o,
  output logic [LEN_W-1:0] len_o,
  output logic             ready_o
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

  logic             active_q, have_len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAC_W-1:0] dst_q;
  logic [LEN_W-1:0] len_q;

  assign ready_o = active_q && have_len_q && (cnt_q == CNT_FULL);
  assign dst_o   = dst_q;
  assign len_o   = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      have_len_q <= 1'b0;
      cnt_q      <= '0;
      dst_q      <= '0;
      len_q      <= '0;
    end else if (byte_valid_i && sof_i) begin
      active_q      <= 1'b1;
      cnt_q         <= CNT_W'(1);
      dst_q[7:0]    <= byte_i;
      have_len_q    <= len_valid_i;
      if (len_valid_i) len_q <= len_i;
    end else begin
      if (active_q && byte_valid_i && cnt_q < CNT_FULL) begin
        dst_q[8*int'(cnt_q) +: 8] <= byte_i;
        cnt_q <= cnt_q + 1'b1;
      end
      if (active_q && len_valid_i && !have_len_q) begin
        have_len_q <= 1'b1;
        len_q      <= len_i;
      end
      if (ready_o) active_q <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL); // R10
  AST_IDLE_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !(byte_valid_i && sof_i) |=> !ready_o); // R10
endmodule

// File: rtl/rxf_bitmap.sv
module rxf_bitmap
  import rxf_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int DEPTH = (2 ** BMAP_IDX_W) / WORD_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int BW    = $clog2(WORD_W)
) (
  input  logic                  clk_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [WORD_W-1:0]     wdata_i,
  input  logic [BMAP_IDX_W-1:0] idx_i,
  output logic                  bit_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rd_word;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rd_word = mem_q[idx_i[BMAP_IDX_W-1:BW]];
  assign bit_o   = rd_word[idx_i[BW-1:0]];
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int NUM_MC = 4,
  parameter int LEN_W  = 14
) (
  input  logic [MAC_W-1:0]        dst_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [MAC_W-1:0]        sta_addr_i,
  input  logic [NUM_MC*MAC_W-1:0] mc_addr_i,
  input  logic [MAC_W-1:0]        xsta_addr_i,
  input  logic                    promisc_i,
  input  logic                    bcast_rej_i,
  input  logic                    mcast_rej_i,
  input  logic                    jumbo_en_i,
  input  logic                    vlan_en_i,
  input  logic                    ext_on_i,
  input  logic                    bmap_bit_i,
  output logic [BMAP_IDX_W-1:0]   bmap_idx_o,
  output frame_cls_t              cls_o,
  output logic                    accept_o
);
  logic [NUM_MC-1:0] mc_hit;
  logic len_bad, basic_ok, ext_ok;

  for (genvar g = 0; g < NUM_MC; g++) begin : g_slot
    assign mc_hit[g] = (dst_i == mc_addr_i[g*MAC_W +: MAC_W]);
  end

  always_comb begin
    cls_o.ucast = ~dst_i[0];
    cls_o.bcast = &dst_i;
    cls_o.mcast = dst_i[0] && !(&dst_i);
    cls_o.ipmc  = cls_o.mcast && (dst_i[23:0] == IPMC_PFX);
  end

  // byte4 low 7 bits above byte5
  assign bmap_idx_o = {dst_i[38:32], dst_i[47:40]};

  assign len_bad = !jumbo_en_i && !vlan_en_i &&
                   (len_i > LEN_W'(STD_MAX_LEN)) && (len_i <= LEN_W'(TAG_MAX_LEN));

  always_comb begin
    if (cls_o.ucast)      basic_ok = (dst_i == sta_addr_i);
    else if (cls_o.bcast) basic_ok = !bcast_rej_i;
    else                  basic_ok = !mcast_rej_i && (|mc_hit);
    if (cls_o.ucast)      ext_ok = (dst_i == xsta_addr_i);
    else if (cls_o.bcast) ext_ok = !bcast_rej_i;
    else                  ext_ok = bmap_bit_i;
  end

  assign accept_o = !len_bad && (promisc_i || basic_ok) && (!ext_on_i || ext_ok);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int NUM_MC  = 4,
  parameter int LEN_W   = 14,
  parameter int WORD_W  = 32,
  localparam int BMAP_AW = $clog2((2 ** BMAP_IDX_W) / WORD_W)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sof_i,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_i,
  input  logic                    len_valid_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [MAC_W-1:0]        sta_addr_i,
  input  logic [NUM_MC*MAC_W-1:0] mc_addr_i,
  input  logic [MAC_W-1:0]        xsta_addr_i,
  input  logic                    promisc_i,
  input  logic                    bcast_rej_i,
  input  logic                    mcast_rej_i,
  input  logic                    jumbo_en_i,
  input  logic                    vlan_en_i,
  input  logic                    ext_fn_en_i,
  input  logic                    ext_mc_en_i,
  input  logic                    bmap_we_i,
  input  logic [BMAP_AW-1:0]      bmap_waddr_i,
  input  logic [WORD_W-1:0]       bmap_wdata_i,
  output logic                    accept_o,
  output logic                    reject_o,
  output logic                    is_ucast_o,
  output logic                    is_bcast_o,
  output logic                    is_mcast_o,
  output logic                    is_ipmc_o
);
  logic [MAC_W-1:0]      dst;
  logic [LEN_W-1:0]      flen;
  logic                  ready, acc, bmap_bit;
  logic [BMAP_IDX_W-1:0] bmap_idx;
  frame_cls_t            cls, cls_q;
  logic                  accept_q, reject_q;

  rxf_capture #(.LEN_W(LEN_W)) u_capture (
    .clk_i, .rst_ni, .sof_i, .byte_valid_i, .byte_i, .len_valid_i, .len_i,
    .dst_o(dst), .len_o(flen), .ready_o(ready)
  );

  rxf_bitmap #(.WORD_W(WORD_W)) u_bitmap (
    .clk_i, .we_i(bmap_we_i), .waddr_i(bmap_waddr_i), .wdata_i(bmap_wdata_i),
    .idx_i(bmap_idx), .bit_o(bmap_bit)
  );

  rxf_decide #(.NUM_MC(NUM_MC), .LEN_W(LEN_W)) u_decide (
    .dst_i(dst), .len_i(flen), .sta_addr_i, .mc_addr_i, .xsta_addr_i,
    .promisc_i, .bcast_rej_i, .mcast_rej_i, .jumbo_en_i, .vlan_en_i,
    .ext_on_i(ext_fn_en_i && ext_mc_en_i), .bmap_bit_i(bmap_bit),
    .bmap_idx_o(bmap_idx), .cls_o(cls), .accept_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      reject_q <= 1'b0;
      cls_q    <= '0;
    end else begin
      accept_q <= ready && acc;
      reject_q <= ready && !acc;
      cls_q    <= ready ? cls : '0;
    end
  end

  assign accept_o   = accept_q;
  assign reject_o   = reject_q;
  assign is_ucast_o = cls_q.ucast;
  assign is_bcast_o = cls_q.bcast;
  assign is_mcast_o = cls_q.mcast;
  assign is_ipmc_o  = cls_q.ipmc;

  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || reject_o) |=> !(accept_o || reject_o)); // R10
  AST_CLASS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || reject_o) |-> $countones({is_ucast_o, is_bcast_o, is_mcast_o}) == 1); // R1
  AST_IPMC_IN_MCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ipmc_o |-> is_mcast_o); // R2
  AST_BCAST_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && is_bcast_o && !$past(promisc_i) |-> !$past(bcast_rej_i)); // R4
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  localparam int NUM_MC = 4;
  localparam int LEN_W  = 14;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic sof, bv, lv;
  logic [7:0] byte_d;
  logic [LEN_W-1:0] len_d;
  logic [47:0] sta, xsta;
  logic [NUM_MC*48-1:0] mc;
  logic promisc, brej, mrej, jumbo, vlan, xfn, xmc;
  logic bwe;
  logic [9:0] bwaddr;
  logic [31:0] bwdata;
  logic acc_o, rej_o, uc_o, bc_o, mc_o, ip_o;

  rx_addr_filter dut (
    .clk_i(clk), .rst_ni, .sof_i(sof), .byte_valid_i(bv), .byte_i(byte_d),
    .len_valid_i(lv), .len_i(len_d), .sta_addr_i(sta), .mc_addr_i(mc),
    .xsta_addr_i(xsta), .promisc_i(promisc), .bcast_rej_i(brej),
    .mcast_rej_i(mrej), .jumbo_en_i(jumbo), .vlan_en_i(vlan),
    .ext_fn_en_i(xfn), .ext_mc_en_i(xmc), .bmap_we_i(bwe),
    .bmap_waddr_i(bwaddr), .bmap_wdata_i(bwdata),
    .accept_o(acc_o), .reject_o(rej_o), .is_ucast_o(uc_o),
    .is_bcast_o(bc_o), .is_mcast_o(mc_o), .is_ipmc_o(ip_o)
  );

  int checks = 0, fails = 0;
  logic [31:0] mirror [1024];
  logic [47:0] dests [8];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mcs(input int s);
    return mc[s*48 +: 48];
  endfunction

  function automatic bit model(input logic [47:0] d, input int len);
    bit uc, bc, ok, hit;
    int idx;
    uc = !d[0];
    bc = (d == 48'hFFFF_FFFF_FFFF);
    ok = 1;
    if (!jumbo && !vlan && len >= 1519 && len <= 1522) ok = 0;
    if (!promisc) begin
      if (uc) ok &= (d == sta);
      else if (bc) ok &= !brej;
      else begin
        hit = 0;
        for (int s = 0; s < NUM_MC; s++) if (mcs(s) == d) hit = 1;
        ok &= !mrej && hit;
      end
    end
    if (xfn && xmc) begin
      if (uc) ok &= (d == xsta);
      else if (bc) ok &= !brej;
      else begin
        idx = int'(d[39:32] & 8'h7F) * 256 + int'(d[47:40]);
        ok &= mirror[idx / 32][idx % 32];
      end
    end
    return ok;
  endfunction

  task automatic send(input logic [47:0] d, input int len, input int len_at,
                      input string tag);
    int hits, first_k, exp_k;
    logic a, r, u, b, m, ip;
    bit e_uc, e_bc, e_mc, e_ip, e_acc;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sof = (i == 0); bv = 1'b1; byte_d = d[8*i +: 8];
      lv = (len_at == i); len_d = LEN_W'(len);
    end
    @(negedge clk);
    sof = 1'b0; bv = 1'b0; lv = (len_at == 6);
    hits = 0; first_k = -1;
    {a, r, u, b, m, ip} = '0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      lv = 1'b0;
      if (acc_o || rej_o) begin
        hits++;
        if (first_k < 0) begin
          first_k = k;
          {a, r, u, b, m, ip} = {acc_o, rej_o, uc_o, bc_o, mc_o, ip_o};
        end
      end
    end
    exp_k = (len_at == 6) ? 2 : 1;
    e_uc = !d[0];
    e_bc = (d == 48'hFFFF_FFFF_FFFF);
    e_mc = !e_uc && !e_bc;
    e_ip = e_mc && d[23:0] == 24'h5E0001;
    e_acc = model(d, len);
    chk(hits == 1, "R10", "strobe count", hits, 1);
    chk(first_k == exp_k, "R10", "strobe latency", first_k, exp_k);
    chk(a != r, "R10", "accept xor reject", {a, r}, 2'b01);
    chk({u, b, m} == {e_uc, e_bc, e_mc}, "R1", "class", {u, b, m}, {e_uc, e_bc, e_mc});
    chk(ip == e_ip, "R2", "ipmc flag", ip, e_ip);
    chk(a == e_acc, tag, "accept (R6 R7 cfg)", a, e_acc);
  endtask

  task automatic wr_bmap(input int w, input logic [31:0] v);
    @(negedge clk);
    bwe = 1'b1; bwaddr = 10'(w); bwdata = v;
    mirror[w] = v;
    @(negedge clk);
    bwe = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    string tags [8];
    sof = 0; bv = 0; lv = 0; byte_d = 0; len_d = 0;
    promisc = 0; brej = 0; mrej = 0; jumbo = 0; vlan = 0; xfn = 0; xmc = 0;
    bwe = 0; bwaddr = 0; bwdata = 0;
    for (int w = 0; w < 1024; w++) mirror[w] = '0;
    sta  = 48'h5544_3322_1100;
    xsta = 48'hAABB_CCDD_EE10;
    mc   = {48'h0000_0000_0103, 48'h0605_0403_0203,
            48'h0A0B_0C0D_0E0F, 48'h4785_115E_0001};
    dests[0] = 48'h5544_3322_1100; tags[0] = "R3";
    dests[1] = 48'h5544_3322_1102; tags[1] = "R3";
    dests[2] = 48'hFFFF_FFFF_FFFF; tags[2] = "R4";
    dests[3] = 48'h0605_0403_0203; tags[3] = "R5";
    dests[4] = 48'h0605_0403_0213; tags[4] = "R5";
    dests[5] = 48'h4785_115E_0001; tags[5] = "R8";
    dests[6] = 48'h4885_115E_0001; tags[6] = "R8";
    dests[7] = 48'hAABB_CCDD_EE10; tags[7] = "R7";

    repeat (3) @(negedge clk);
    // R11: outputs quiet in reset
    chk({acc_o, rej_o, uc_o, bc_o, mc_o, ip_o} == '0, "R11", "reset outputs",
        {acc_o, rej_o, uc_o, bc_o, mc_o, ip_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk({acc_o, rej_o} == '0, "R11", "idle after reset", {acc_o, rej_o}, 0);

    // R8: idx 0x0547 -> word 42 bit 7 set; idx 0x0548 -> bit 8 clear
    wr_bmap(42, 32'h0000_0080);

    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      promisc = c[0]; brej = c[1]; mrej = c[2]; xfn = c[3]; xmc = c[4];
      for (int d = 0; d < 8; d++)
        send(dests[d], 64 + d, ((c + d) % 3 == 0) ? 6 : d % 6, tags[d]);
    end

    // R9: length window sweep, destination otherwise accepted
    promisc = 0; brej = 0; mrej = 0; xfn = 0; xmc = 0;
    for (int j = 0; j < 4; j++) begin
      int lens [7] = '{64, 1518, 1519, 1520, 1522, 1523, 2000};
      jumbo = j[0]; vlan = j[1];
      for (int l = 0; l < 7; l++) send(dests[0], lens[l], l % 7, "R9");
    end
    jumbo = 0; vlan = 0;
    send(dests[3], 1521, 6, "R9");
    promisc = 1;
    send(dests[1], 1520, 5, "R9");

    // R10: trailing bytes and lengths after a decision are ignored
    send(dests[0], 100, 0, "R10");
    @(negedge clk); bv = 1; byte_d = 8'h33; lv = 1; len_d = 14'd77;
    @(negedge clk); bv = 0; lv = 0;
    repeat (3) begin
      @(negedge clk);
      chk({acc_o, rej_o} == '0, "R10", "no strobe without sof", {acc_o, rej_o}, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule